// File: doc/BRIEF.md
# Fractional Divider Trim Sequencer

This block keeps the feedback divider word of an external programmable oscillator, so that a digital loop can steer the oscillator's output frequency. The word is a fixed-point value made of a 9-bit integer part and a 29-bit fraction, 38 bits in all. A loop filter presents signed correction steps in units of one fraction LSB. Each step is added to the word, and the sum is limited to a window that the system supplies as precomputed lower and upper bounds around a stored centre value. The block then turns the word into a series of byte-write requests for an I2C master.

Steps arrive on a valid/ready input. `step_ready` drops when a nonzero step is accepted and stays low until the last byte write has been handed off, so the loop filter must hold its step until it sees ready. The write output is also valid/ready: the I2C master can stall any byte by holding `wr_ready` low, and the block keeps the address and data steady until the byte is taken. The byte that carries the upper integer bits goes out last, and that write commits the new divider value in the oscillator.

Top module: `frac_trim_seq`

## Requirements
- R1: While `rst_n` is low, the working word is loaded from `centre_m`. After reset, `step_ready` is 1, `wr_valid` is 0 and `clamp_flag` is 0.
- R2: An accepted step (`step_valid` and `step_ready` high at a clock edge) adds the sign-extended `step_val` to the 38-bit word {integer[8:0], fraction[28:0]}. A carry out of the fraction or a borrow into it changes the integer part.
- R3: If the sum is above `upper_m`, the word becomes `upper_m`. If it is below `lower_m`, the word becomes `lower_m`.
- R4: `clamp_flag` is set at the edge that accepts a step that R3 limited. It stays set until a cycle in which `clamp_clear` is high and no clamped step is accepted; a clamped step in the same cycle as `clamp_clear` leaves it set.
- R5: After a nonzero step, exactly five writes follow, to addresses `BASE_ADDR`+0 through +4 in rising order. The write at offset k carries bits [8k+7:8k] of the word with zero padding: offsets 0–2 hold fraction bits 23:0, offset 3 holds {integer[2:0], fraction[28:24]}, and offset 4 holds {2'b00, integer[8:3]} and is always last.
- R6: `step_ready` is low from the edge that accepts a nonzero step until the edge at which the offset-4 write is handed off. No step is taken in that time, and `wr_valid` is never high while `step_ready` is high.
- R7: A step of zero is accepted, produces no write, and leaves the word and `step_ready` unchanged.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the centre word |
| centre_m | input | 38 | Centre divider word {int, frac} |
| upper_m | input | 38 | Highest permitted divider word |
| lower_m | input | 38 | Lowest permitted divider word |
| step_valid | input | 1 | Correction step present |
| step_ready | output | 1 | Block can take a step |
| step_val | input | 24 | Signed correction in fraction LSBs |
| clamp_clear | input | 1 | Clears the clamp flag |
| clamp_flag | output | 1 | Sticky: a step was limited by the window |
| wr_valid | output | 1 | Byte-write request present |
| wr_ready | input | 1 | I2C master takes the request |
| wr_addr | output | 8 | Register address of the byte |
| wr_data | output | 8 | Byte value |

## Verification
The assertions assume that `lower_m <= centre_m <= upper_m`, that the three bound inputs stay constant outside reset, and that `step_val` fits in its signed width. The window assertion depends on these assumptions. The bench loads each centre and its ±2^20 window only while reset is held, and it builds every step as a signed 24-bit value. Its step sweep runs across the fraction carry and borrow edges and well past both bounds. The bench toggles `wr_ready` in several patterns, and it holds a different step on `step_valid` during every write series, so that any step taken while the block is busy would show in the next series of writes.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SEND = 1'b1
  } seq_state_t;

  function automatic int bytes_for(input int bits);
    return (bits + 7) / 8;
  endfunction
endpackage

// File: rtl/trim_accum.sv
module trim_accum #(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 29,
  parameter int STEP_W = 24,
  localparam int W = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      centre_m,
  input  logic [W-1:0]      upper_m,
  input  logic [W-1:0]      lower_m,
  input  logic              load,
  input  logic [STEP_W-1:0] step,
  input  logic              clamp_clear,
  output logic [W-1:0]      m_q,
  output logic              clamp_flag
);
  localparam int EW = W + 2;

  logic signed [EW-1:0] cur_s, stp_s, sum_s, hi_s, lo_s;
  logic                 hit_hi, hit_lo;
  logic [W-1:0]         m_next;

  always_comb begin
    cur_s  = $signed({2'b00, m_q});
    stp_s  = $signed({{(EW-STEP_W){step[STEP_W-1]}}, step});
    hi_s   = $signed({2'b00, upper_m});
    lo_s   = $signed({2'b00, lower_m});
    sum_s  = cur_s + stp_s;
    hit_hi = sum_s > hi_s;
    hit_lo = sum_s < lo_s;
    if (hit_hi)      m_next = upper_m;
    else if (hit_lo) m_next = lower_m;
    else             m_next = sum_s[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q        <= centre_m;
      clamp_flag <= 1'b0;
    end else begin
      if (load) m_q <= m_next;
      if (load && (hit_hi || hit_lo)) clamp_flag <= 1'b1;
      else if (clamp_clear)          clamp_flag <= 1'b0;
    end
  end

  // Bounds are assumed steady outside reset, with the centre inside them.
  assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q <= upper_m) && (m_q >= lower_m));

  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_flag) |-> $past(load));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_flag && !clamp_clear |=> clamp_flag);

  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load && (step == '0) |=> m_q == $past(m_q));
endmodule

// File: rtl/byte_write_seq.sv
module byte_write_seq
  import trim_pkg::*;
#(
  parameter int          W         = 38,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'h07,
  localparam int NBYTES = bytes_for(W),
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      word,
  output logic              busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  seq_state_t            state;
  logic [IDX_W-1:0]      idx;
  logic [NBYTES*8-1:0]   padded;
  logic [7:0]            lanes [NBYTES];

  assign padded = (NBYTES*8)'(word);

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign lanes[k] = padded[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          state <= SEQ_SEND;
          idx   <= '0;
        end
        SEQ_SEND: if (wr_ready) begin
          if (idx == LAST) state <= SEQ_IDLE;
          else             idx   <= idx + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy     = (state == SEQ_SEND);
  assign wr_valid = busy;
  assign wr_addr  = ADDR_W'(BASE_ADDR) + ADDR_W'(idx);
  assign wr_data  = lanes[idx];

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && (idx == LAST) |=> !wr_valid);

  assert_first_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> wr_addr == ADDR_W'(BASE_ADDR));
endmodule

// File: rtl/frac_trim_seq.sv
module frac_trim_seq #(
  parameter int         INT_W     = 9,
  parameter int         FRAC_W    = 29,
  parameter int         STEP_W    = 24,
  parameter logic [7:0] BASE_ADDR = 8'h07,
  localparam int W = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      centre_m,
  input  logic [W-1:0]      upper_m,
  input  logic [W-1:0]      lower_m,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic [STEP_W-1:0] step_val,
  input  logic              clamp_clear,
  output logic              clamp_flag,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [7:0]        wr_addr,
  output logic [7:0]        wr_data
);
  logic         accept, busy;
  logic [W-1:0] m_q;

  assign step_ready = !busy;
  assign accept     = step_valid && step_ready;

  trim_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .centre_m(centre_m), .upper_m(upper_m),
    .lower_m(lower_m), .load(accept), .step(step_val),
    .clamp_clear(clamp_clear), .m_q(m_q), .clamp_flag(clamp_flag)
  );

  byte_write_seq #(.W(W), .ADDR_W(8), .BASE_ADDR(BASE_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept && (step_val != '0)),
    .word(m_q), .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !step_ready);

  assert_zero_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_ready && (step_val == '0) |=> !wr_valid && step_ready);

  assert_nonzero_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_ready && (step_val != '0) |=> wr_valid && !step_ready);
endmodule

// File: tb/frac_trim_seq_test.sv
`timescale 1ns/1ps
module frac_trim_seq_test;
  localparam int W = 38;
  localparam logic [7:0] BASE = 8'h07;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [W-1:0] centre_m = '0, upper_m = '0, lower_m = '0;
  logic step_valid = 1'b0, clamp_clear = 1'b0, wr_ready = 1'b0;
  logic [23:0] step_val = '0;
  logic step_ready, clamp_flag, wr_valid;
  logic [7:0] wr_addr, wr_data;

  frac_trim_seq uut (
    .clk(clk), .rst_n(rst_n), .centre_m(centre_m), .upper_m(upper_m),
    .lower_m(lower_m), .step_valid(step_valid), .step_ready(step_ready),
    .step_val(step_val), .clamp_clear(clamp_clear), .clamp_flag(clamp_flag),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int errors = 0, checks = 0;
  longint m_exp;
  bit flag_exp;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input longint c);
    rst_n = 1'b0;
    centre_m = W'(c);
    upper_m  = W'(c + (longint'(1) << 20));
    lower_m  = W'(c - (longint'(1) << 20));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(step_ready == 1'b1, "R1 ready", step_ready, 1);
    chk(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    chk(clamp_flag == 1'b0, "R1 flag", clamp_flag, 0);
    m_exp = c;  // R1: first write series reveals centre plus step
    flag_exp = 1'b0;
  endtask

  task automatic do_clear();
    clamp_clear = 1'b1;
    @(negedge clk);
    clamp_clear = 1'b0;
    flag_exp = 1'b0;
    chk(clamp_flag == 1'b0, "R4 clear", clamp_flag, 0);
  endtask

  task automatic do_step(input longint s, input int pat);
    longint sum;
    bit clamped;
    logic [7:0] hold_a, hold_d;
    bit hold_pend;
    int k, cyc;
    chk(step_ready == 1'b1, "R6 ready idle", step_ready, 1);
    step_valid = 1'b1;
    step_val   = s[23:0];
    @(negedge clk);
    sum = m_exp + s;
    clamped = 1'b0;
    if (sum > longint'(upper_m))      begin m_exp = longint'(upper_m); clamped = 1'b1; end
    else if (sum < longint'(lower_m)) begin m_exp = longint'(lower_m); clamped = 1'b1; end
    else m_exp = sum;
    if (clamped) flag_exp = 1'b1;
    if (s == 0) begin
      step_valid = 1'b0;
      for (int j = 0; j < 3; j++) begin
        chk(!wr_valid && step_ready, "R7 no traffic", {wr_valid, step_ready}, 1);
        @(negedge clk);
      end
    end else begin
      step_val  = ~s[23:0];  // held while busy; must not be taken (R6)
      k = 0; cyc = 0; hold_pend = 1'b0;
      while (k < 5 && cyc < 60) begin
        chk(!step_ready, "R6 busy", step_ready, 0);
        if (hold_pend) begin
          chk(wr_valid && wr_addr == hold_a && wr_data == hold_d, "R8 hold",
              {wr_valid, wr_addr, wr_data}, {1'b1, hold_a, hold_d});
          hold_pend = 1'b0;
        end
        wr_ready = ((cyc + pat) % 3) != 0;
        if (wr_valid && wr_ready) begin
          chk(wr_addr == BASE + 8'(k), "R5 addr", wr_addr, BASE + k);
          chk(wr_data == 8'((m_exp >> (8 * k)) & 8'hFF),
              clamped ? "R3 clamped byte" : "R2 sum byte", wr_data, (m_exp >> (8 * k)) & 8'hFF);
          if (k == 4) chk(wr_data[7:6] == 2'b00, "R5 top pad", wr_data, m_exp >> 32);
          k++;
        end else if (wr_valid) begin
          hold_a = wr_addr; hold_d = wr_data; hold_pend = 1'b1;
        end
        cyc++;
        @(negedge clk);
      end
      step_valid = 1'b0;
      wr_ready   = 1'b0;
      chk(step_ready && !wr_valid, "R6 ready after last", {step_ready, wr_valid}, 2);
    end
    chk(clamp_flag == flag_exp, "R4 flag", clamp_flag, flag_exp);
  endtask

  function automatic longint step_for(input int i);
    longint b;
    b = longint'((i * 2654435) % 8191) - 4095;
    return b <<< (i % 12);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Pass A: fraction all ones, +1 carries into the integer part (R2)
    do_reset({9'd71, 29'h1FFFFFFF});
    do_step(1, 0);
    do_step(-1, 1);
    for (int i = 1; i < 40; i++) begin
      if (i % 7 == 0) do_step(0, i);
      else            do_step(step_for(i), i);
      if (i % 10 == 0) do_clear();
    end
    do_step(longint'(1) << 22, 2);  // far above window (R3)
    do_step(longint'(1) << 22, 0);  // already at upper bound
    do_clear();
    // Pass B: fraction zero, -1 borrows from the integer part (R2)
    do_reset({9'd72, 29'h0});
    do_step(-1, 2);
    do_step(1, 0);
    for (int i = 40; i < 80; i++) begin
      if (i % 7 == 0) do_step(0, i);
      else            do_step(-step_for(i), i);
      if (i % 10 == 0) do_clear();
    end
    do_step(-(longint'(1) << 23), 1);  // far below window (R3)
    do_step(0, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule